// File: doc/BRIEF.md
# Control-Word Ripple ALU

This block is a combinational arithmetic and logic unit of parameterised width (4 bits by default). It takes two operands and a carry input. It has no opcode decoder. Instead, a 7-bit control word steers every bit slice through a set of independent switches:

- inversion of either operand bit;
- enabling of the incoming carry into the result;
- extra XOR terms;
- a choice between showing the slice's sum-type result or its carry-type result.

These switches are set independently, and their combinations yield addition, subtraction, the per-bit carries or borrows of either, OR, pass-through and many other operations.

Every slice is identical, and carries ripple from bit 0 upward. The carry chain always behaves as a full adder acting on the conditioned operands, whatever the output selection. This means the final carry and the exported internal carries stay meaningful in every mode. The block has no clock and no state. Its outputs follow its inputs after the ripple delay.

Top module: `alu_ctrlword`

## Requirements

- R1: Operand conditioning is applied in every slice i before any other logic. The slice forms x = a[i] XOR ctrl[2] and y = b[i] XOR ctrl[1].
- R2: When ctrl[6] = 0, result[i] = x ^ y ^ (ctrl[3] & c) ^ (ctrl[4] & x) ^ ctrl[5]. Here c is the carry into slice i.
- R3: When ctrl[6] = 1, result[i] = ctrl[0] ^ (x & y) ^ (ctrl[3] & c & (x ^ y)).
- R4: The carry out of slice i is (x & y) | (c & (x ^ y)). The carry into slice 0 is cin. carries[i] is the carry out of slice i, and cout equals carries[WIDTH-1]. None of these depend on ctrl[3], ctrl[4], ctrl[5] or ctrl[6].
- R5: With ctrl = 7'b0001000, result = (a + b + cin) mod 2^WIDTH and cout is the carry out of that addition.
- R6: With ctrl = 7'b1001000, result equals carries, the per-bit carry vector of a + b + cin.
- R7: With ctrl = 7'b0101100, result = (a - b - cin) mod 2^WIDTH, treating cin as a borrow in. In this mode cout = 1 exactly when b + cin > a.
- R8: With ctrl = 7'b1101100, result equals carries, which is the per-bit borrow vector of the subtraction in R7.
- R9: With ctrl = 7'b1000111, result = a | b.
- R10: With ctrl = 7'b0010000, result = b. In this mode a and cin have no effect on result.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| ctrl | input | 7 | Control word; bit meanings are given in R1 to R3 |
| cin | input | 1 | Carry (or borrow) into slice 0 |
| result | output | WIDTH | Result vector |
| cout | output | 1 | Carry out of the top slice |
| carries | output | WIDTH | Carry out of every slice |

## Verification

The bound checker re-evaluates a set of relations whenever any input or output changes:

- the carry vector and cout match an integer addition of the conditioned operands, whatever the output selection;
- with carry view and no final XOR, result equals the carry vector;
- with carry view and the carry term off, result reduces to a bitwise AND of the conditioned operands;
- in the pure sum code, result is the truncated sum.

The remaining behaviour needs the bench's scenarios to show it. That behaviour is the interaction of the ctrl[4] and ctrl[5] XOR terms, the arithmetic meaning of the subtract and borrow codes, OR, and pass-through with a and cin toggled. The bench checks these against reference functions built per slice from the equations, both with random control words and exhaustively over operands for the named codes.

// File: rtl/alu_cw_pkg.sv
package alu_cw_pkg;

    localparam int CTRL_W = 7;

    typedef struct packed {
        logic sel_carry;   // bit 6: show carry-type result
        logic inv_sum;     // bit 5: constant XOR in sum view
        logic x_fold;      // bit 4: fold conditioned a into sum view
        logic chain_en;    // bit 3: carry term enters the result
        logic flip_a;      // bit 2: invert operand a
        logic flip_b;      // bit 1: invert operand b
        logic carry_xor;   // bit 0: constant XOR in carry view
    } ctrl_t;

    localparam logic [CTRL_W-1:0] OP_ADD      = 7'b0001000;
    localparam logic [CTRL_W-1:0] OP_ADD_CY   = 7'b1001000;
    localparam logic [CTRL_W-1:0] OP_SUB      = 7'b0101100;
    localparam logic [CTRL_W-1:0] OP_SUB_BRW  = 7'b1101100;
    localparam logic [CTRL_W-1:0] OP_OR       = 7'b1000111;
    localparam logic [CTRL_W-1:0] OP_PASS_B   = 7'b0010000;

endpackage

// File: rtl/alu_cw_prep.sv
module alu_cw_prep #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             flip_a,
    input  logic             flip_b,
    output logic [WIDTH-1:0] x_out,
    output logic [WIDTH-1:0] y_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cond
        assign x_out[i] = a_in[i] ^ flip_a;
        assign y_out[i] = b_in[i] ^ flip_b;
    end
endmodule

// File: rtl/alu_cw_slice.sv
module alu_cw_slice (
    input  logic x,
    input  logic y,
    input  logic c_prev,
    input  logic sel_carry,
    input  logic inv_sum,
    input  logic x_fold,
    input  logic chain_en,
    input  logic carry_xor,
    output logic r,
    output logic c_next
);
    logic prop;
    logic gen;
    logic cin_term;
    logic sum_view;
    logic cy_view;

    always_comb begin
        prop     = x ^ y;
        gen      = x & y;
        cin_term = chain_en & c_prev;
        // carry always uses the full-adder form, independent of chain_en
        c_next   = gen ^ (prop & c_prev);
        sum_view = prop ^ cin_term ^ (x_fold & x) ^ inv_sum;
        cy_view  = carry_xor ^ gen ^ (cin_term & prop);
        r        = sel_carry ? cy_view : sum_view;
    end
endmodule

// File: rtl/alu_cw_chain.sv
module alu_cw_chain
    import alu_cw_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             c_in,
    input  ctrl_t            cw,
    output logic [WIDTH-1:0] r_vec,
    output logic [WIDTH-1:0] c_vec
);
    logic [WIDTH:0] ripple;
    assign ripple[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_cw_slice u_slice (
            .x         (x_vec[i]),
            .y         (y_vec[i]),
            .c_prev    (ripple[i]),
            .sel_carry (cw.sel_carry),
            .inv_sum   (cw.inv_sum),
            .x_fold    (cw.x_fold),
            .chain_en  (cw.chain_en),
            .carry_xor (cw.carry_xor),
            .r         (r_vec[i]),
            .c_next    (ripple[i+1])
        );
    end

    assign c_vec = ripple[WIDTH:1];
endmodule

// File: rtl/alu_ctrlword.sv
module alu_ctrlword
    import alu_cw_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              cin,
    output logic [WIDTH-1:0]  result,
    output logic              cout,
    output logic [WIDTH-1:0]  carries
);
    localparam int TOP = WIDTH - 1;

    ctrl_t            cw;
    logic [WIDTH-1:0] x_vec;
    logic [WIDTH-1:0] y_vec;

    assign cw = ctrl_t'(ctrl);

    alu_cw_prep #(.WIDTH(WIDTH)) u_prep (
        .a_in   (op_a),
        .b_in   (op_b),
        .flip_a (cw.flip_a),
        .flip_b (cw.flip_b),
        .x_out  (x_vec),
        .y_out  (y_vec)
    );

    alu_cw_chain #(.WIDTH(WIDTH)) u_chain (
        .x_vec (x_vec),
        .y_vec (y_vec),
        .c_in  (cin),
        .cw    (cw),
        .r_vec (result),
        .c_vec (carries)
    );

    assign cout = carries[TOP];
endmodule

// File: rtl/alu_ctrlword_chk.sv
module alu_ctrlword_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [6:0]       ctrl,
    input logic             cin,
    input logic [WIDTH-1:0] result,
    input logic             cout,
    input logic [WIDTH-1:0] carries
);
    logic [WIDTH-1:0] xa;
    logic [WIDTH-1:0] yb;
    logic [WIDTH:0]   total;

    always_comb begin
        xa    = op_a ^ {WIDTH{ctrl[2]}};
        yb    = op_b ^ {WIDTH{ctrl[1]}};
        total = {1'b0, xa} + {1'b0, yb} + {{WIDTH{1'b0}}, cin};
    end

    // R4: final carry follows the integer sum of the conditioned operands
    always_comb begin
        assert_cout_sum_R4: assert (cout == total[WIDTH])
            else $error("cout does not match conditioned sum");
    end

    // R4: every internal carry is the carry out of the low i+1 bits
    for (genvar i = 0; i < WIDTH; i++) begin : g_cy
        logic [i+1:0] part;
        always_comb begin
            part = {1'b0, xa[i:0]} + {1'b0, yb[i:0]} + {{(i+1){1'b0}}, cin};
            assert_carry_bit_R4: assert (carries[i] == part[i+1])
                else $error("carries[%0d] wrong", i);
        end
    end

    // R3/R6/R8: carry view with no extra XOR exposes the carry vector
    always_comb begin
        if (ctrl[6] && ctrl[3] && !ctrl[0]) begin
            assert_carry_view_R3: assert (result == carries)
                else $error("carry view differs from carries");
        end
    end

    // R3: carry view without the carry term is AND of conditioned operands
    always_comb begin
        if (ctrl[6] && !ctrl[3]) begin
            assert_and_view_R3: assert (result == ((xa & yb) ^ {WIDTH{ctrl[0]}}))
                else $error("carry view without chain wrong");
        end
    end

    // R5: pure add code gives the truncated sum
    always_comb begin
        if (ctrl == 7'b0001000) begin
            assert_add_sum_R5: assert (result == total[WIDTH-1:0])
                else $error("add result wrong");
        end
    end
endmodule

bind alu_ctrlword alu_ctrlword_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .ctrl    (ctrl),
    .cin     (cin),
    .result  (result),
    .cout    (cout),
    .carries (carries)
);

// File: tb/sim_alu_ctrlword.sv
`timescale 1ns/1ps
module sim_alu_ctrlword;
    localparam int W = 4;
    localparam int WATCH_CYC = 150000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [6:0]   ctrl = '0;
    logic         cin  = 1'b0;
    logic [W-1:0] result;
    logic         cout;
    logic [W-1:0] carries;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    alu_ctrlword #(.WIDTH(W)) u0 (
        .op_a(op_a), .op_b(op_b), .ctrl(ctrl), .cin(cin),
        .result(result), .cout(cout), .carries(carries)
    );

    // per-slice reference from R1..R4
    function automatic logic [2*W:0] ref_model(input logic [W-1:0] a,
            input logic [W-1:0] b, input logic [6:0] s, input logic ci);
        logic [W-1:0] r;
        logic [W-1:0] cv;
        logic c;
        c = ci;
        for (int i = 0; i < W; i++) begin
            logic x, y;
            x = a[i] ^ s[2];
            y = b[i] ^ s[1];
            if (!s[6]) r[i] = x ^ y ^ (s[3] & c) ^ (s[4] & x) ^ s[5];
            else       r[i] = s[0] ^ (x & y) ^ (s[3] & c & (x ^ y));
            c = (x & y) | (c & (x ^ y));
            cv[i] = c;
        end
        return {c, cv, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h ctrl=%b cin=%b actual=%h expected=%h",
                     req, op_a, op_b, ctrl, cin, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [6:0] s, input logic ci);
        @(posedge clk);
        op_a = a; op_b = b; ctrl = s; cin = ci;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCH_CYC) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [2*W:0] m;
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // reset-like idle state: all zero inputs
        @(negedge clk);
        check("R2 idle", {31'd0, result}, 32'd0);
        check("R4 idle", {31'd0, cout}, 32'd0);

        // random control words against the slice reference (R1..R4)
        for (int n = 0; n < 8000; n++) begin
            logic [W-1:0] a, b;
            logic [6:0] s;
            logic ci;
            a = W'($urandom); b = W'($urandom); s = 7'($urandom); ci = 1'($urandom);
            apply(a, b, s, ci);
            m = ref_model(a, b, s, ci);
            if (s[6]) check("R3 result", 32'(result), 32'(m[W-1:0]));
            else      check("R2 result", 32'(result), 32'(m[W-1:0]));
            check("R1 R4 carries", 32'(carries), 32'(m[2*W-1:W]));
            check("R4 cout", 32'(cout), 32'(m[2*W]));
        end

        // directed named codes, exhaustive over operands
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int sum, dif;
                    logic [W-1:0] cy;
                    sum = a + b + ci;
                    dif = a - b - ci;
                    apply(W'(a), W'(b), 7'b0001000, 1'(ci));
                    check("R5 sum", 32'(result), 32'(sum % (1 << W)));
                    check("R5 cout", 32'(cout), 32'(sum >= (1 << W)));
                    cy = carries;
                    for (int i = 0; i < W; i++) begin
                        int part;
                        part = (a % (1 << (i+1))) + (b % (1 << (i+1))) + ci;
                        check("R4 carry bit", 32'(cy[i]), 32'(part >= (1 << (i+1))));
                    end
                    apply(W'(a), W'(b), 7'b1001000, 1'(ci));
                    check("R6 carry view", 32'(result), 32'(cy));
                    apply(W'(a), W'(b), 7'b0101100, 1'(ci));
                    check("R7 diff", 32'(result), 32'(dif & ((1 << W) - 1)));
                    check("R7 borrow out", 32'(cout), 32'((b + ci) > a));
                    cy = carries;
                    apply(W'(a), W'(b), 7'b1101100, 1'(ci));
                    check("R8 borrow view", 32'(result), 32'(cy));
                    apply(W'(a), W'(b), 7'b1000111, 1'(ci));
                    check("R9 or", 32'(result), 32'(a | b));
                    apply(W'(a), W'(b), 7'b0010000, 1'(ci));
                    check("R10 pass b", 32'(result), 32'(b));
                end
            end
        end

        // R10: toggling a and cin leaves the pass-through result unchanged
        apply(4'h0, 4'hA, 7'b0010000, 1'b0);
        check("R10 base", 32'(result), 32'hA);
        apply(4'hF, 4'hA, 7'b0010000, 1'b1);
        check("R10 a/cin toggled", 32'(result), 32'hA);

        done = 1;
        finish_run();
    end
endmodule